// File: doc/BRIEF.md
# Pipelined Direct-Form FIR Filter

This block convolves a stream of 8-bit signed samples with a fixed set of 32 signed 8-bit coefficients and returns each result at full precision. A sample is accepted on any clock edge where the input strobe is high. Each accepted sample enters a tapped delay line, and each tap feeds its own multiplier. The 32 products are then summed by a balanced adder tree with a register at every level. No adder chain therefore runs from the first tap to the last, and the longest path between registers is one multiplier or one adder. The price is a fixed output latency of six cycles.

Each product comes from a hierarchical multiplier. It splits each operand into halves, forms four half-width partial products, and recurses down to 2x2 gate-level cells. Signs are handled by multiplying magnitudes and negating the product when needed. Every addition in the block goes through a carry-select adder, in which each block precomputes both carry cases and the incoming carry picks one. The coefficients are fixed when the design is elaborated. For matched-filter use, the sampled reference pulse is loaded with its first sample at the highest tap index.

Top module: `pipe_fir`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid` is 0 and `out_data` is 0. The sample history is all zeros, so the first results after reset treat every earlier sample as 0.
- R2: For the n-th accepted sample, `out_data` (signed two's complement) equals the sum over k = 0..31 of c[k]·x[n−k]. Here x[n] is the newest sample, c[k] = ((29·k + 3) mod 256) − 128, and samples not yet received count as 0.
- R3: The result is 21 bits wide and exact. Full-scale inputs of −128 or +127 produce the exact sum without wrap.
- R4: `out_valid` goes high for one cycle exactly 6 rising edges after the edge that accepted the matching sample. There is exactly one result per accepted sample and none otherwise.
- R5: On an edge where `in_valid` is low, `in_sample` is ignored and the sample history does not move. Results after an idle gap are the same as if the gap were absent.
- R6: A new sample may be accepted on every edge, and a result then appears on every cycle.
- R7: A single sample of value 1 followed by zeros produces the coefficients c[0], c[1], …, c[31] on successive results.
- R8: A synchronous reset during streaming discards every result still in flight and clears the history. No `out_valid` appears until a new sample has been accepted and 6 edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the sample is accepted on the edge where this is high |
| in_sample | input | 8 | Signed input sample |
| out_valid | output | 1 | High for one cycle with each result |
| out_data | output | 21 | Signed full-precision filter result |

## Verification
The hardest situation to reach from the ports is a reset arriving while six results are partway through the multiplier and adder-tree stages. In that case both the pending strobes and the history must vanish. The stimulus reaches it by streaming a burst on back-to-back edges and raising reset in the cycle right after the last sample. It then watches `out_valid` stay low for longer than the pipeline depth, and follows with a fresh stream whose expected values assume an all-zero history. Idle gaps of varying length are placed between samples with junk on `in_sample`, so that a shift on an idle edge would show up in later results.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // Width of one carry-select block; every adder in the filter uses it.
    localparam int CSA_BLK = 4;

    // Power-of-two test used for the multiplier recursion width.
    function automatic bit is_pow2(input int v);
        return (v > 1) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fir_csel_add.sv
module fir_csel_add #(
    parameter int W   = 8,
    parameter int BLK = fir_pkg::CSA_BLK
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NB = (W + BLK - 1) / BLK;

    logic [NB:0] cy;
    assign cy[0] = cin;

    for (genvar g = 0; g < NB; g++) begin : g_blk
        // The last block takes whatever bits remain.
        localparam int BW = (g == NB - 1) ? (W - (NB - 1) * BLK) : BLK;
        localparam int LO = g * BLK;

        logic [BW:0] r_c0;
        logic [BW:0] r_c1;

        // Both carry-in cases are formed in parallel.
        assign r_c0 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]};
        assign r_c1 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]} + (BW+1)'(1);

        // The carry out of the previous block picks one of them.
        assign sum[LO +: BW] = cy[g] ? r_c1[BW-1:0] : r_c0[BW-1:0];
        assign cy[g+1]       = cy[g] ? r_c1[BW]     : r_c0[BW];
    end

    assign cout = cy[NB];

endmodule

// File: rtl/fir_vedic_mul.sv
module fir_vedic_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    if (W == 2) begin : g_cell
        logic pp00, pp01, pp10, pp11, c1;
        assign pp00 = a[0] & b[0];
        assign pp01 = a[0] & b[1];
        assign pp10 = a[1] & b[0];
        assign pp11 = a[1] & b[1];
        assign c1   = pp01 & pp10;
        assign p[0] = pp00;
        assign p[1] = pp01 ^ pp10;
        assign p[2] = pp11 ^ c1;
        assign p[3] = pp11 & c1;
    end else begin : g_split
        localparam int H = W / 2;

        logic [W-1:0]   q_ll, q_hl, q_lh, q_hh;
        logic [W-1:0]   cross_s;
        logic           cross_c;
        logic [W+H-1:0] upper_s;
        logic           top_unused;

        fir_vedic_mul #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));
        fir_vedic_mul #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(q_hl));
        fir_vedic_mul #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(q_lh));
        fir_vedic_mul #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(q_hh));

        // Sum of the two cross products, keeping its carry.
        fir_csel_add #(.W(W)) u_cross (
            .a   (q_hl),
            .b   (q_lh),
            .cin (1'b0),
            .sum (cross_s),
            .cout(cross_c)
        );

        // Upper half: high-high product over the spill of low-low, plus cross sum.
        fir_csel_add #(.W(W + H)) u_upper (
            .a   ({q_hh, q_ll[W-1:H]}),
            .b   ({{(H-1){1'b0}}, cross_c, cross_s}),
            .cin (1'b0),
            .sum (upper_s),
            .cout(top_unused)
        );

        assign p = {upper_s, q_ll[H-1:0]};
    end

endmodule

// File: rtl/fir_tap_mult.sv
module fir_tap_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   c,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0]  x_neg, c_neg, x_mag, c_mag;
    logic [PW-1:0] m_pos, m_neg;
    logic          xc_unused, cc_unused, pc_unused;
    logic          flip;

    // Two's-complement magnitude of each operand; -2^(W-1) maps to 2^(W-1).
    fir_csel_add #(.W(W)) u_xneg (
        .a(~x), .b('0), .cin(1'b1), .sum(x_neg), .cout(xc_unused)
    );
    fir_csel_add #(.W(W)) u_cneg (
        .a(~c), .b('0), .cin(1'b1), .sum(c_neg), .cout(cc_unused)
    );

    assign x_mag = x[W-1] ? x_neg : x;
    assign c_mag = c[W-1] ? c_neg : c;

    fir_vedic_mul #(.W(W)) u_core (.a(x_mag), .b(c_mag), .p(m_pos));

    fir_csel_add #(.W(PW)) u_pneg (
        .a(~m_pos), .b('0), .cin(1'b1), .sum(m_neg), .cout(pc_unused)
    );

    assign flip = x[W-1] ^ c[W-1];
    assign prod = flip ? m_neg : m_pos;

endmodule

// File: rtl/pipe_fir.sv
module pipe_fir
    import fir_pkg::*;
#(
    parameter int NTAPS     = 32,
    parameter int W         = 8,
    parameter int COEF_STEP = 29,
    parameter int COEF_BASE = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [W-1:0]                     in_sample,
    output logic                             out_valid,
    output logic [2*W+$clog2(NTAPS)-1:0]     out_data
);
    localparam int PW       = 2 * W;
    localparam int GROW     = $clog2(NTAPS);
    localparam int ACC_W    = PW + GROW;
    localparam int PIPE_LAT = 1 + GROW;

    // Coefficient k = ((STEP*k + BASE) mod 2^W) - 2^(W-1), stored as W-bit code.
    function automatic logic [NTAPS-1:0][W-1:0] build_coefs();
        logic [NTAPS-1:0][W-1:0] t;
        for (int k = 0; k < NTAPS; k++) begin
            t[k] = W'((COEF_STEP * k + COEF_BASE) % (1 << W)) ^ W'(1 << (W - 1));
        end
        return t;
    endfunction

    localparam logic [NTAPS-1:0][W-1:0] COEF_TBL = build_coefs();

    typedef struct packed {
        logic [NTAPS-1:0][W-1:0]     taps;   // index 0 holds the newest sample
        logic [NTAPS-1:0][PW-1:0]    prod;   // registered tap products
        logic [NTAPS-1:1][ACC_W-1:0] node;   // heap-ordered adder tree, root at 1
        logic [PIPE_LAT:0]           vld;    // strobe shadow of the datapath
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic [NTAPS-1:0][PW-1:0]    mul_p;
    logic [NTAPS-1:1][ACC_W-1:0] add_s;
    logic [NTAPS-1:0][W-1:0]     dline_q;

    assign dline_q = st_q.taps;

    // One multiplier per tap.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        fir_tap_mult #(.W(W)) u_mul (
            .x   (st_q.taps[k]),
            .c   (COEF_TBL[k]),
            .prod(mul_p[k])
        );
    end

    // Adder tree: node i sums its children 2i and 2i+1; children at or above
    // NTAPS are the registered products, sign-extended to the accumulator width.
    for (genvar i = 1; i < NTAPS; i++) begin : g_node
        logic [ACC_W-1:0] lhs, rhs;
        logic             carry_unused;

        if (2 * i >= NTAPS) begin : g_from_prod
            assign lhs = {{GROW{st_q.prod[2*i-NTAPS][PW-1]}},   st_q.prod[2*i-NTAPS]};
            assign rhs = {{GROW{st_q.prod[2*i+1-NTAPS][PW-1]}}, st_q.prod[2*i+1-NTAPS]};
        end else begin : g_from_node
            assign lhs = st_q.node[2*i];
            assign rhs = st_q.node[2*i+1];
        end

        fir_csel_add #(.W(ACC_W)) u_add (
            .a   (lhs),
            .b   (rhs),
            .cin (1'b0),
            .sum (add_s[i]),
            .cout(carry_unused)
        );
    end

    always_comb begin
        st_d = st_q;

        if (in_valid) begin
            st_d.taps[0] = in_sample;
            for (int k = 1; k < NTAPS; k++) begin
                st_d.taps[k] = st_q.taps[k-1];
            end
        end

        st_d.prod = mul_p;
        st_d.node = add_s;
        st_d.vld  = {st_q.vld[PIPE_LAT-1:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld[PIPE_LAT];
    assign out_data  = st_q.node[1];

endmodule

// File: rtl/pipe_fir_chk.sv
module pipe_fir_chk #(
    parameter int NTAPS = 32,
    parameter int W     = 8,
    parameter int AW    = 21,
    parameter int LAT   = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [W-1:0]             in_sample,
    input logic                     out_valid,
    input logic [AW-1:0]            out_data,
    input logic [NTAPS-1:0][W-1:0]  dline
);
    localparam longint LIM = longint'(NTAPS) * (longint'(1) << (2 * W - 2));

    logic [LAT:0] strobe_sh;
    logic         was_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_sh <= '0;
        end else begin
            strobe_sh <= {strobe_sh[LAT-1:0], in_valid};
        end
    end

    // R1 / R8: an edge with reset high leaves outputs and history cleared.
    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (was_rst) begin
            a_reset_clear_r1: assert (!out_valid && out_data == '0 && dline == '0)
                else $error("R1/R8: state not cleared after reset");
        end
    end

    // R4: result strobe appears exactly LAT edges after each accepted sample.
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid == strobe_sh[LAT]);

    // R2: an accepted sample becomes the newest tap.
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> dline[0] == $past(in_sample));

    // R2: older samples move one tap on.
    p_age_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> dline[NTAPS-1:1] == $past(dline[NTAPS-2:0]));

    // R5: idle edges leave the history untouched.
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dline));

    // R3: a valid result never exceeds the full-scale bound.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_data)) <= LIM &&
                       longint'($signed(out_data)) >= -LIM));

endmodule

bind pipe_fir pipe_fir_chk #(
    .NTAPS(NTAPS),
    .W    (W),
    .AW   (ACC_W),
    .LAT  (PIPE_LAT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_data (out_data),
    .dline    (dline_q)
);

// File: tb/pipe_fir_tb.sv
module pipe_fir_tb;
    localparam int NT      = 32;
    localparam int LATENCY = 6;
    localparam int NVEC    = 40;

    // {idle cycles before sample, sample}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0005, 16'h00FB, 16'h0080, 16'h007F, 16'h0100, 16'h00FF, 16'h0201, 16'h0033,
        16'h00C4, 16'h0312, 16'h0080, 16'h0080, 16'h0170, 16'h00E0, 16'h000F, 16'h02F1,
        16'h007F, 16'h0000, 16'h0099, 16'h0166, 16'h0023, 16'h00DD, 16'h0302, 16'h00FE,
        16'h0041, 16'h00BF, 16'h0110, 16'h0080, 16'h007F, 16'h0208, 16'h00F8, 16'h0055,
        16'h00AA, 16'h0101, 16'h007E, 16'h0081, 16'h0300, 16'h0044, 16'h00BC, 16'h0019
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = 8'h00;
    logic        out_valid;
    logic [20:0] out_data;

    always #4 clk = ~clk;

    pipe_fir u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0;
    int    fails  = 0;
    int    hist [NT];
    int    exp_val [4096];
    int    exp_cyc [4096];
    string exp_tag [4096];
    int    wr = 0;
    int    rd = 0;

    function automatic int bcoef(input int k);
        return ((29 * k + 3) % 256) - 128;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        in_valid  = 1'b0;
        in_sample = 8'hA5;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(input logic [7:0] s, input string tag);
        int acc;
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(s));
        acc = 0;
        for (int k = 0; k < NT; k++) acc += bcoef(k) * hist[k];
        exp_val[wr] = acc;
        exp_cyc[wr] = cyc + 1 + LATENCY;
        exp_tag[wr] = tag;
        wr++;
        in_valid  = 1'b1;
        in_sample = s;
        tick();
        in_valid  = 1'b0;
        in_sample = 8'hA5;
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        in_valid = 1'b0;
        rd = wr;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        for (int i = 0; i < n; i++) tick();
        rst = 1'b0;
    endtask

    task automatic check_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s out_valid after reset actual=%0b expected=0", tag, out_valid);
            end
            tick();
        end
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (rd != wr) begin
            fails++;
            $display("FAIL %s results delivered actual=%0d expected=%0d", tag, rd, wr);
        end
    endtask

    // Scoreboard: compare every result strobe with the reference convolution.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd == wr) begin
                checks++;
                fails++;
                $display("FAIL R4 unexpected out_valid actual=1 expected=0");
            end else begin
                checks++;
                if (int'($signed(out_data)) != exp_val[rd]) begin
                    fails++;
                    $display("FAIL %s result #%0d actual=%0d expected=%0d",
                             exp_tag[rd], rd, int'($signed(out_data)), exp_val[rd]);
                end
                checks++;
                if (cyc != exp_cyc[rd]) begin
                    fails++;
                    $display("FAIL R4 latency of result #%0d actual=%0d expected=%0d",
                             rd, cyc, exp_cyc[rd]);
                end
                rd++;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < NT; k++) hist[k] = 0;

        // R1: reset state
        for (int i = 0; i < 3; i++) tick();
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
        end
        checks++;
        if (out_data !== 21'd0) begin
            fails++;
            $display("FAIL R1 out_data in reset actual=%0d expected=0", out_data);
        end
        rst = 1'b0;
        check_quiet(LATENCY + 2, "R1");

        // R2 / R5: table walk with idle gaps and junk on the sample input
        for (int i = 0; i < NVEC; i++) begin
            idle(int'(VEC[i][15:8]));
            push(VEC[i][7:0], (VEC[i][15:8] != 8'd0) ? "R5" : "R2");
        end
        idle(LATENCY + 3);
        check_drained("R4");

        // R7: impulse response from a cleared history
        do_reset(2);
        push(8'h01, "R7");
        for (int i = 1; i < NT + 2; i++) push(8'h00, "R7");
        idle(LATENCY + 3);
        check_drained("R7");

        // R3: full-scale inputs of both signs, then alternating extremes
        do_reset(2);
        for (int i = 0; i < NT + 4; i++) push(8'h80, "R3");
        for (int i = 0; i < NT + 4; i++) push(8'h7F, "R3");
        for (int i = 0; i < NT + 4; i++) push((i % 2 == 0) ? 8'h80 : 8'h7F, "R3");
        idle(LATENCY + 3);
        check_drained("R3");

        // R6: one sample on every edge
        for (int i = 0; i < 50; i++) push(8'((i * 37 + 11) % 256), "R6");
        idle(LATENCY + 3);
        check_drained("R6");

        // R8: reset right after a burst, with results still in flight
        for (int i = 0; i < 10; i++) push(8'((i * 53 + 7) % 256), "R8");
        do_reset(1);
        check_quiet(LATENCY + 4, "R8");
        for (int i = 0; i < 12; i++) push(8'((i * 19 + 90) % 256), "R8");
        idle(LATENCY + 3);
        check_drained("R8");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule